// File: doc/BRIEF.md
# Multipass Equivalent-Time Sampling Controller

This controller lets a slow converter record a fast, strictly periodic waveform. It runs several acquisition passes. Each pass is locked to a pulse that marks the start of a signal period, and within a pass the converter is triggered at a fixed real interval. From one pass to the next, the first trigger moves later by a fraction of that interval. If there are NPASS passes and the interval is INTERVAL clocks, the shift per pass is SHIFT = INTERVAL / NPASS clocks.

Each result is written to a memory port at an address built from its in-pass sample index and its pass number. When the last pass finishes, the memory therefore holds one signal period in time order, at NPASS times the converter's real rate. The analog front end and the converter itself are outside the block. The controller only issues trigger strobes, accepts completion pulses with data, and reports completion and an overrun condition.

Top module: `ets_sampler`

## Requirements
- R1: Reset behaviour. While `rst` is high and after it falls, `conv_start`, `mem_we`, `acq_done` and `overrun` are all 0, and no trigger is issued until an acquisition is started.
- R2: Starting an acquisition.
  - A `start_cmd` pulse while idle begins an acquisition at pass 0.
  - It clears `acq_done` and `overrun`; both read 0 in the cycle after the edge that samples it.
  - `start_cmd` has no effect while an acquisition is in progress.
- R3: Synchronisation.
  - Every pass waits for `sync_pulse` before it issues any trigger.
  - `sync_pulse` is ignored while idle and while a pass is sampling.
  - `conv_start` is never high outside a running pass.
- R4: Trigger timing.
  - Count the edge that samples `sync_pulse` for pass p (p = 0 .. NPASS-1) as edge 0.
  - When the converter is free, the k-th trigger of that pass (k = 0 .. NSAMP-1) is a one-cycle `conv_start` pulse driven by edge 1 + p*SHIFT + k*INTERVAL.
  - Each pass issues exactly NSAMP trigger slots.
- R5: Writing results.
  - A `conv_done` pulse during an outstanding conversion causes a one-cycle `mem_we` in the next cycle.
  - That write carries `mem_wdata` = the `conv_data` sampled with `conv_done`.
  - Its address is `mem_addr` = k*NPASS + p, where k is the trigger index of that conversion and p is the pass.
  - So address a holds the sample taken 1 + a*SHIFT edges after its pass's sync edge.
- R6: Converter busy.
  - `conv_start` is never issued between a trigger and the edge that samples its `conv_done`.
  - A trigger that falls due while the converter is busy is deferred, keeping its index, and is issued once the converter is free.
- R7: Overrun.
  - If a trigger falls due while another one is already deferred, `overrun` is set.
  - The newer trigger is dropped, so its memory slot is not written.
  - The acquisition still completes.
  - `overrun` stays set until the next accepted `start_cmd`.
- R8: Completion.
  - `acq_done` rises only after the final write of the last pass.
  - It then stays high until the next accepted `start_cmd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_cmd | input | 1 | Begin a new acquisition (accepted when idle) |
| sync_pulse | input | 1 | One-cycle marker of the signal period start |
| conv_start | output | 1 | One-cycle converter trigger |
| conv_done | input | 1 | One-cycle converter completion |
| conv_data | input | 8 | Converter result, valid with `conv_done` |
| mem_we | output | 1 | Record memory write enable |
| mem_addr | output | 5 | Record memory address (sample*NPASS + pass) |
| mem_wdata | output | 8 | Record memory write data |
| acq_done | output | 1 | All passes complete; held until next start |
| overrun | output | 1 | Sticky flag: a trigger was dropped |

## Verification
The bench models the converter with a variable latency. It feeds back a value that depends only on the cycle distance from the last sync edge. A controller that used the wrong per-pass offset, or placed samples in the wrong slot, would leave a record that is not a clean time-ordered period, and the bench checks every slot against the value for 1 + a*SHIFT.

Slow-converter runs exercise the busy and deferral paths, where a wrong design would trigger during a conversion or lose track of indices. Very slow runs must raise `overrun` and still finish without writing any slot twice, where a wrong design would hang or overwrite slots.

Directed cases cover the remaining control paths:
- Syncs while idle must produce no triggers.
- Starting with the sync held off must produce no triggers.
- A stray `start_cmd` in mid-acquisition must not restart the passes, which would show up as extra writes.

// File: rtl/ets_pkg.sv
package ets_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } ets_state_e;

    typedef struct packed {
        logic fire;   // a trigger slot falls due this cycle
        logic last;   // it is the final slot of the pass
    } ets_due_t;

    // width of an index counting 0..n-1, never zero
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // record slot of trigger k in pass p: time-ordered interleave
    function automatic int slot_of(input int k, input int p, input int npass);
        return k * npass + p;
    endfunction

    // delay from sync to first slot of pass p
    function automatic int pass_offset(input int p, input int shift);
        return p * shift;
    endfunction

endpackage

// File: rtl/ets_pacer.sv
module ets_pacer
    import ets_pkg::*;
#(
    parameter int NPASS    = 4,
    parameter int NSAMP    = 8,
    parameter int INTERVAL = 20
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        arm,
    input  logic [idx_w(NPASS)-1:0]     pass_idx,
    output ets_due_t                    due,
    output logic [idx_w(NSAMP)-1:0]     due_idx,
    output logic                        all_issued
);
    localparam int SHIFT = INTERVAL / NPASS;
    localparam int SW    = idx_w(NSAMP);
    localparam int TW    = $clog2(INTERVAL + 1);

    logic [TW-1:0] tick;
    logic [SW-1:0] cnt;
    logic          active;

    assign due.fire   = active && (tick == '0);
    assign due.last   = (cnt == SW'(NSAMP - 1));
    assign due_idx    = cnt;
    assign all_issued = !active;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            tick   <= '0;
            cnt    <= '0;
        end else if (arm) begin
            active <= 1'b1;
            tick   <= TW'(pass_offset(int'(pass_idx), SHIFT));
            cnt    <= '0;
        end else if (due.fire) begin
            tick <= TW'(INTERVAL - 1);
            cnt  <= cnt + 1'b1;
            if (due.last) active <= 1'b0;
        end else if (active) begin
            tick <= tick - 1'b1;
        end
    end

    // R4: slots are at least INTERVAL apart, never back to back
    a_r4_due_spaced: assert property (@(posedge clk) disable iff (rst)
        due.fire |=> !due.fire);

    // R4: after the last slot of a pass no further slot fires until re-armed
    a_r4_last_slot: assert property (@(posedge clk) disable iff (rst)
        (due.fire && due.last && !arm) |=> all_issued);

endmodule

// File: rtl/ets_launch.sv
module ets_launch
    import ets_pkg::*;
#(
    parameter int NSAMP = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    due_fire,
    input  logic [idx_w(NSAMP)-1:0] due_idx,
    input  logic                    conv_done,
    output logic                    conv_start,
    output logic                    busy,
    output logic                    pending,
    output logic                    overrun,
    output logic [idx_w(NSAMP)-1:0] fly_idx
);
    localparam int SW = idx_w(NSAMP);

    logic [SW-1:0] pend_idx;
    logic          issue_pend;

    assign issue_pend = pending && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_start <= 1'b0;
            busy       <= 1'b0;
            pending    <= 1'b0;
            overrun    <= 1'b0;
            fly_idx    <= '0;
            pend_idx   <= '0;
        end else begin
            conv_start <= 1'b0;
            if (clr) begin
                busy    <= 1'b0;
                pending <= 1'b0;
                overrun <= 1'b0;
            end else begin
                if (busy && conv_done) busy <= 1'b0;
                if (issue_pend) begin
                    conv_start <= 1'b1;
                    busy       <= 1'b1;
                    fly_idx    <= pend_idx;
                    pending    <= due_fire;
                    if (due_fire) pend_idx <= due_idx;
                end else if (due_fire) begin
                    if (!busy) begin
                        conv_start <= 1'b1;
                        busy       <= 1'b1;
                        fly_idx    <= due_idx;
                    end else if (!pending) begin
                        pending  <= 1'b1;
                        pend_idx <= due_idx;
                    end else begin
                        overrun <= 1'b1;
                    end
                end
            end
        end
    end

    // R6: no trigger while a conversion is outstanding
    a_r6_no_start_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> !conv_start);

    // R6: triggers are single-cycle pulses
    a_r6_start_pulse: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    // R7: overrun is sticky until cleared by an accepted start
    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        (overrun && !clr) |=> overrun);

endmodule

// File: rtl/ets_store.sv
module ets_store
    import ets_pkg::*;
#(
    parameter int NPASS  = 4,
    parameter int NSAMP  = 8,
    parameter int DATA_W = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                conv_done,
    input  logic                                busy,
    input  logic [DATA_W-1:0]                   conv_data,
    input  logic [idx_w(NSAMP)-1:0]             fly_idx,
    input  logic [idx_w(NPASS)-1:0]             pass_idx,
    output logic                                mem_we,
    output logic [idx_w(NPASS*NSAMP)-1:0]       mem_addr,
    output logic [DATA_W-1:0]                   mem_wdata
);
    localparam int DEPTH  = NPASS * NSAMP;
    localparam int ADDR_W = idx_w(DEPTH);

    logic take;
    assign take = conv_done && busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= take;
            if (take) begin
                mem_addr  <= ADDR_W'(slot_of(int'(fly_idx), int'(pass_idx), NPASS));
                mem_wdata <= conv_data;
            end
        end
    end

    // R5: each write follows a completion of an outstanding conversion
    a_r5_write_after_done: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ($past(conv_done) && $past(busy)));

    // R5: addresses stay inside the record
    a_r5_addr_in_range: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (int'(mem_addr) < DEPTH));

endmodule

// File: rtl/ets_sampler.sv
module ets_sampler
    import ets_pkg::*;
#(
    parameter int NPASS    = 4,
    parameter int NSAMP    = 8,
    parameter int INTERVAL = 20,
    parameter int DATA_W   = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            start_cmd,
    input  logic                            sync_pulse,
    output logic                            conv_start,
    input  logic                            conv_done,
    input  logic [DATA_W-1:0]               conv_data,
    output logic                            mem_we,
    output logic [idx_w(NPASS*NSAMP)-1:0]   mem_addr,
    output logic [DATA_W-1:0]               mem_wdata,
    output logic                            acq_done,
    output logic                            overrun
);
    localparam int PW = idx_w(NPASS);
    localparam int SW = idx_w(NSAMP);

    ets_state_e    state;
    logic [PW-1:0] pass_idx;
    logic          accept, arm, pass_end, pass_last;
    ets_due_t      due;
    logic [SW-1:0] due_idx, fly_idx;
    logic          all_issued, busy, pending;

    assign accept    = (state == ST_IDLE) && start_cmd;
    assign arm       = (state == ST_WAIT) && sync_pulse;
    assign pass_last = (pass_idx == PW'(NPASS - 1));
    assign pass_end  = (state == ST_RUN) && all_issued && !busy && !pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pass_idx <= '0;
            acq_done <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    state    <= ST_WAIT;
                    pass_idx <= '0;
                    acq_done <= 1'b0;
                end
                ST_WAIT: if (arm) state <= ST_RUN;
                ST_RUN: if (pass_end) begin
                    if (pass_last) begin
                        state    <= ST_IDLE;
                        acq_done <= 1'b1;
                    end else begin
                        state    <= ST_WAIT;
                        pass_idx <= pass_idx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    ets_pacer #(.NPASS(NPASS), .NSAMP(NSAMP), .INTERVAL(INTERVAL)) u_pacer (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm),
        .pass_idx  (pass_idx),
        .due       (due),
        .due_idx   (due_idx),
        .all_issued(all_issued)
    );

    ets_launch #(.NSAMP(NSAMP)) u_launch (
        .clk       (clk),
        .rst       (rst),
        .clr       (accept),
        .due_fire  (due.fire),
        .due_idx   (due_idx),
        .conv_done (conv_done),
        .conv_start(conv_start),
        .busy      (busy),
        .pending   (pending),
        .overrun   (overrun),
        .fly_idx   (fly_idx)
    );

    ets_store #(.NPASS(NPASS), .NSAMP(NSAMP), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .conv_done(conv_done),
        .busy     (busy),
        .conv_data(conv_data),
        .fly_idx  (fly_idx),
        .pass_idx (pass_idx),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata)
    );

    // R2: an accepted start clears completion and overrun
    a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
        accept |=> (!acq_done && !overrun));

    // R3: triggers only appear inside a running pass
    a_r3_start_in_run: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> (state == ST_RUN));

    // R8: completion holds until a new start
    a_r8_done_holds: assert property (@(posedge clk) disable iff (rst)
        (acq_done && !start_cmd) |=> acq_done);

    // R8: no record write once completion is reported
    a_r8_no_write_after_done: assert property (@(posedge clk) disable iff (rst)
        acq_done |-> !mem_we);

endmodule

// File: tb/tb_ets_sampler.sv
module tb_ets_sampler;
    localparam int CLK_PERIOD = 10;
    localparam int NPASS    = 4;
    localparam int NSAMP    = 8;
    localparam int INTERVAL = 20;
    localparam int DATA_W   = 8;
    localparam int SHIFT    = INTERVAL / NPASS;
    localparam int DEPTH    = NPASS * NSAMP;
    localparam int ADDR_W   = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_cmd = 1'b0;
    logic sync_pulse = 1'b0;
    logic conv_start;
    logic conv_done = 1'b0;
    logic [DATA_W-1:0] conv_data = '0;
    logic mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic acq_done;
    logic overrun;

    ets_sampler #(.NPASS(NPASS), .NSAMP(NSAMP), .INTERVAL(INTERVAL), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst), .start_cmd(start_cmd), .sync_pulse(sync_pulse),
        .conv_start(conv_start), .conv_done(conv_done), .conv_data(conv_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .acq_done(acq_done), .overrun(overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    always @(posedge clk) cyc = cyc + 1;

    // stimulus knobs
    int conv_lat = 3;
    int sync_per = 220;
    bit sync_en = 1'b0;
    int sig_a = 3;
    int sig_b = 0;
    bit time_chk = 1'b0;

    // observation state
    int sync_edge = 0;
    int n_starts = 0;
    int acq_starts = 0;
    int n_wr = 0;
    int last_wr_cyc = 0;
    int wr_cnt [DEPTH];
    logic [DATA_W-1:0] mem_img [DEPTH];

    function automatic logic [DATA_W-1:0] sig_val(input int t);
        return DATA_W'((sig_a * t + sig_b) & 255);
    endfunction

    function automatic int exp_phase(input int p, input int k);
        return 1 + p * SHIFT + k * INTERVAL;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // sync generator
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (sync_en) begin
                cnt++;
                if (cnt >= sync_per) begin
                    sync_pulse = 1'b1;
                    sync_edge = cyc + 1;
                    cnt = 0;
                end else sync_pulse = 1'b0;
            end else begin
                sync_pulse = 1'b0;
                cnt = 0;
            end
        end
    end

    // converter model: value depends only on distance from last sync edge
    initial begin
        bit mbusy = 1'b0;
        int left = 0;
        logic [DATA_W-1:0] cap = '0;
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            if (conv_start && mbusy)
                check(1'b0, "R6 start while converting", 1, 0);
            if (mbusy) begin
                if (left == 0) begin
                    conv_done = 1'b1;
                    conv_data = cap;
                    mbusy = 1'b0;
                end else left--;
            end
            if (conv_start) begin
                int ph;
                ph = cyc - sync_edge;
                n_starts++;
                if (time_chk) begin
                    int p, k;
                    p = acq_starts / NSAMP;
                    k = acq_starts % NSAMP;
                    check(ph == exp_phase(p, k), "R4 trigger edge", ph, exp_phase(p, k));
                end
                acq_starts++;
                cap = sig_val(ph);
                left = conv_lat;
                mbusy = 1'b1;
            end
        end
    end

    // record memory model
    initial begin
        forever begin
            @(negedge clk);
            if (mem_we) begin
                n_wr++;
                last_wr_cyc = cyc;
                wr_cnt[int'(mem_addr)]++;
                mem_img[int'(mem_addr)] = mem_wdata;
            end
        end
    end

    // mode 0: clean timing, 1: deferral, 2: overrun
    task automatic run_acq(input int mode, input int lat, input int per,
                           input int hold, input bit mid_cmd);
        int it;
        int done_cyc;
        conv_lat = lat;
        sync_per = per;
        time_chk = (mode == 0);
        acq_starts = 0;
        n_wr = 0;
        for (int i = 0; i < DEPTH; i++) begin wr_cnt[i] = 0; mem_img[i] = '0; end
        @(negedge clk);
        start_cmd = 1'b1;
        @(negedge clk);
        start_cmd = 1'b0;
        check(acq_done == 1'b0, "R2 done cleared", int'(acq_done), 0);
        check(overrun == 1'b0, "R2 overrun cleared", int'(overrun), 0);
        if (hold > 0) begin
            repeat (hold) @(negedge clk);
            check(acq_starts == 0, "R3 no trigger before sync", acq_starts, 0);
        end
        sync_en = 1'b1;
        it = 0;
        while (!acq_done && it < 30000) begin
            @(negedge clk);
            it++;
            if (mid_cmd) start_cmd = (it == 400);
        end
        start_cmd = 1'b0;
        sync_en = 1'b0;
        done_cyc = cyc;
        check(acq_done == 1'b1, "R8 completion reached", int'(acq_done), 1);
        check(done_cyc > last_wr_cyc, "R8 done after last write", done_cyc, last_wr_cyc + 1);
        if (mode == 2) begin
            check(overrun == 1'b1, "R7 overrun raised", int'(overrun), 1);
            check(n_wr < DEPTH, "R7 dropped slot", n_wr, DEPTH - 1);
        end else begin
            check(overrun == 1'b0, "R7 no overrun", int'(overrun), 0);
            check(n_wr == DEPTH, "R5 write count", n_wr, DEPTH);
        end
        for (int a = 0; a < DEPTH; a++) begin
            if (mode == 2) check(wr_cnt[a] <= 1, "R7 slot written once", wr_cnt[a], 1);
            else check(wr_cnt[a] == 1, "R5 slot written once", wr_cnt[a], 1);
            if (mode == 0)
                check(mem_img[a] == sig_val(1 + a * SHIFT), "R5 slot value",
                      int'(mem_img[a]), int'(sig_val(1 + a * SHIFT)));
        end
        repeat (8) @(negedge clk);
        check(acq_done == 1'b1, "R8 done holds", int'(acq_done), 1);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int s0, w0;
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(negedge clk);
        check(conv_start == 1'b0 && mem_we == 1'b0, "R1 reset outputs", int'(conv_start | mem_we), 0);
        check(acq_done == 1'b0 && overrun == 1'b0, "R1 reset flags", int'(acq_done | overrun), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        // R3: syncs while idle after reset trigger nothing
        sync_en = 1'b1; sync_per = 30;
        repeat (100) @(negedge clk);
        sync_en = 1'b0;
        check(n_starts == 0, "R1 R3 idle ignores sync", n_starts, 0);

        // directed: minimal latency, no hold
        sig_a = 1; sig_b = 0;
        run_acq(0, 0, 200, 0, 1'b0);
        // directed: hold sync off after start, stray start mid-run (R2, R3)
        sig_a = 37; sig_b = 11;
        run_acq(0, INTERVAL - 3, 240, 150, 1'b1);
        // random clean runs
        for (int r = 0; r < 5; r++) begin
            sig_a = int'($urandom_range(127, 0)) * 2 + 1;
            sig_b = int'($urandom_range(255, 0));
            run_acq(0, int'($urandom_range(INTERVAL - 3, 0)),
                    int'($urandom_range(280, 200)), 0, 1'b0);
        end
        // R6: converter slower than interval, deferral without overrun
        run_acq(1, INTERVAL, 400, 0, 1'b0);
        // R7: converter much slower, overrun
        run_acq(2, 2 * INTERVAL + 5, 500, 0, 1'b0);
        // R2: a clean run afterwards clears overrun (checked inside)
        sig_a = 5; sig_b = 200;
        run_acq(0, 2, 210, 0, 1'b0);

        // R3: syncs after completion trigger nothing and write nothing
        s0 = n_starts; w0 = n_wr;
        sync_en = 1'b1; sync_per = 40;
        repeat (200) @(negedge clk);
        sync_en = 1'b0;
        check(n_starts == s0, "R3 no trigger when idle", n_starts, s0);
        check(n_wr == w0, "R3 no write when idle", n_wr, w0);
        check(acq_done == 1'b1, "R8 done held while idle", int'(acq_done), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule